// File: doc/BRIEF.md
# Secure-Scan Mode Controller

This block decides whether a crypto core is open for scan test or closed for normal keyed operation. Out of power-on reset it sits in a test mode. In that mode the scan chain may be shifted and observed, and the core's datapath sees a mirror key that test software writes. The real secret key is kept out of that path.

One test-controller instruction moves the block into secure mode. A strobe marks each new instruction, and the block acts only when the instruction code equals a parameter value. In secure mode both scan permissions are withdrawn, scan requests are ignored and the chain output is held at 0. The mirror key is wiped and the datapath takes the secret key. The only exit from secure mode is the asynchronous active-low reset. No instruction and no other input sequence leads back to test mode.

Top module: `secure_scan_ctrl`

## Requirements
- R1: While `rst_ni` is low and after it is released, the block is in test mode: `scan_in_en_o`=1, `scan_out_en_o`=1, `load_key_o`=0 and `mirror_key_o`=0.
- R2: In test mode `scan_shift_o` follows `scan_en_i` and `scan_out_o` follows `scan_data_i`, both combinationally.
- R3: In secure mode `scan_in_en_o`=0, `scan_out_en_o`=0 and `load_key_o`=1, and `scan_shift_o` and `scan_out_o` are 0 whatever `scan_en_i` and `scan_data_i` carry.
- R4: `key_o` equals `mirror_key_o` in test mode and `secret_key_i` in secure mode. In test mode, a write with `mirror_wr_i`=1 at a rising edge shows on `mirror_key_o` after that edge.
- R5: A 0-to-1 transition of `ir_update_i`, seen at a rising edge while `ir_i` equals `SECURE_CODE` (default 4'hA), raises `load_key_o` after the next rising edge, two edges after the strobe is first sampled. Any other code does nothing. A strobe that is held high triggers at most once, and only on its rising transition.
- R6: The mirror key register is cleared to 0 at the same edge at which `load_key_o` rises, and `mirror_wr_i` has no effect in secure mode.
- R7: Once in secure mode, no combination of inputs other than `rst_ni` low returns the block to test mode.
- R8: `rst_ni` going low forces test mode at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ir_i | input | IR_W | Current test-controller instruction |
| ir_update_i | input | 1 | Strobe marking a newly loaded instruction |
| scan_en_i | input | 1 | Scan shift request |
| scan_data_i | input | 1 | Serial output of the core's scan chain |
| mirror_wr_i | input | 1 | Mirror key write enable |
| mirror_data_i | input | KEY_W | Mirror key write data |
| secret_key_i | input | KEY_W | Secret key from secure storage |
| scan_in_en_o | output | 1 | Permission to shift data into the chain |
| scan_out_en_o | output | 1 | Permission to observe the chain |
| load_key_o | output | 1 | High while the datapath uses the secret key |
| scan_shift_o | output | 1 | Gated scan shift enable to the core |
| scan_out_o | output | 1 | Gated scan output to the pin |
| key_o | output | KEY_W | Key delivered to the datapath |
| mirror_key_o | output | KEY_W | Current mirror key register value |

## Verification
The scan gating and the key mux are combinational. Their results are sampled 1 ns after the driving edge, within the same cycle as the stimulus. A mirror key write appears one edge after it is sampled. Secure entry takes two edges: one edge registers the decoded pulse and the next sets the mode. The bench therefore checks that the mode has not changed after the first edge and that it has changed after the second. The reset check is made a fraction of a cycle after `rst_ni` falls, with no clock edge in between, so that the asynchronous path is exercised.

// File: rtl/secscan_pkg.sv
package secscan_pkg;
  typedef enum logic {
    MODE_TEST   = 1'b0,
    MODE_SECURE = 1'b1
  } mode_e;
endpackage

// File: rtl/secscan_ir_decode.sv
module secscan_ir_decode #(
  parameter int unsigned IR_W = 4,
  parameter logic [IR_W-1:0] SECURE_CODE = 4'hA
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [IR_W-1:0] ir_i,
  input  logic            ir_update_i,
  output logic            go_secure_o
);
  logic upd_q, pulse_q;

  // one pulse per strobe rising edge with a matching code
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_q   <= 1'b0;
      pulse_q <= 1'b0;
    end else begin
      upd_q   <= ir_update_i;
      pulse_q <= ir_update_i & ~upd_q & (ir_i == SECURE_CODE);
    end
  end

  assign go_secure_o = pulse_q;
endmodule

// File: rtl/secscan_mode_fsm.sv
module secscan_mode_fsm
  import secscan_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic go_secure_i,
  output logic secure_o
);
  mode_e mode_q, mode_d;

  // one-way: no transition back to MODE_TEST except via reset
  always_comb begin
    mode_d = mode_q;
    if (go_secure_i) mode_d = MODE_SECURE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= MODE_TEST;
    else         mode_q <= mode_d;
  end

  assign secure_o = (mode_q == MODE_SECURE);
endmodule

// File: rtl/secscan_mirror_key.sv
module secscan_mirror_key #(
  parameter int unsigned KEY_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clear_i,
  input  logic             lock_i,
  input  logic             wr_i,
  input  logic [KEY_W-1:0] data_i,
  output logic [KEY_W-1:0] key_o
);
  logic [KEY_W-1:0] key_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            key_q <= '0;
    else if (clear_i)       key_q <= '0;
    else if (wr_i && !lock_i) key_q <= data_i;
  end

  assign key_o = key_q;
endmodule

// File: rtl/secure_scan_ctrl.sv
module secure_scan_ctrl #(
  parameter int unsigned IR_W = 4,
  parameter int unsigned KEY_W = 16,
  parameter logic [IR_W-1:0] SECURE_CODE = 4'hA
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IR_W-1:0]  ir_i,
  input  logic             ir_update_i,
  input  logic             scan_en_i,
  input  logic             scan_data_i,
  input  logic             mirror_wr_i,
  input  logic [KEY_W-1:0] mirror_data_i,
  input  logic [KEY_W-1:0] secret_key_i,
  output logic             scan_in_en_o,
  output logic             scan_out_en_o,
  output logic             load_key_o,
  output logic             scan_shift_o,
  output logic             scan_out_o,
  output logic [KEY_W-1:0] key_o,
  output logic [KEY_W-1:0] mirror_key_o
);
  logic go_secure;
  logic secure;

  secscan_ir_decode #(.IR_W(IR_W), .SECURE_CODE(SECURE_CODE)) u_dec (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ir_i        (ir_i),
    .ir_update_i (ir_update_i),
    .go_secure_o (go_secure)
  );

  secscan_mode_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .go_secure_i (go_secure),
    .secure_o    (secure)
  );

  // clear lands on the same edge the mode flips
  secscan_mirror_key #(.KEY_W(KEY_W)) u_mkey (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clear_i (go_secure),
    .lock_i  (secure),
    .wr_i    (mirror_wr_i),
    .data_i  (mirror_data_i),
    .key_o   (mirror_key_o)
  );

  assign scan_in_en_o  = ~secure;
  assign scan_out_en_o = ~secure;
  assign load_key_o    = secure;
  assign scan_shift_o  = scan_en_i & scan_in_en_o;
  assign scan_out_o    = scan_data_i & scan_out_en_o;
  assign key_o         = secure ? secret_key_i : mirror_key_o;
endmodule

// File: rtl/secure_scan_chk.sv
module secure_scan_chk #(
  parameter int unsigned KEY_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             go_secure,
  input logic             scan_in_en_o,
  input logic             scan_out_en_o,
  input logic             load_key_o,
  input logic             scan_shift_o,
  input logic             scan_out_o,
  input logic [KEY_W-1:0] key_o,
  input logic [KEY_W-1:0] mirror_key_o,
  input logic [KEY_W-1:0] secret_key_i
);
  p_test_mode_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_key_o |-> (scan_in_en_o && scan_out_en_o));

  p_secure_gate_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_key_o |-> (!scan_in_en_o && !scan_out_en_o && !scan_shift_o && !scan_out_o));

  p_key_sel_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_key_o |-> (key_o == secret_key_i));

  p_entry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_secure |=> load_key_o);

  p_mirror_clear_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_key_o |-> (mirror_key_o == '0));

  p_sticky_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_key_o |=> load_key_o);
endmodule

bind secure_scan_ctrl secure_scan_chk #(.KEY_W(KEY_W)) u_chk (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .go_secure     (go_secure),
  .scan_in_en_o  (scan_in_en_o),
  .scan_out_en_o (scan_out_en_o),
  .load_key_o    (load_key_o),
  .scan_shift_o  (scan_shift_o),
  .scan_out_o    (scan_out_o),
  .key_o         (key_o),
  .mirror_key_o  (mirror_key_o),
  .secret_key_i  (secret_key_i)
);

// File: tb/secure_scan_ctrl_bench.sv
`timescale 1ns/1ps
module secure_scan_ctrl_bench;
  localparam int IR_W = 4;
  localparam int KEY_W = 16;
  localparam logic [3:0] CODE = 4'hA;
  localparam logic [15:0] SECRET = 16'hC3E1;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [IR_W-1:0] ir = '0;
  logic ir_upd = 1'b0, scan_en = 1'b0, scan_data = 1'b0, mwr = 1'b0;
  logic [KEY_W-1:0] mdata = '0;
  logic sin_en, sout_en, load_key, shift, sout;
  logic [KEY_W-1:0] key, mkey;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  secure_scan_ctrl #(.IR_W(IR_W), .KEY_W(KEY_W), .SECURE_CODE(CODE)) u_secure_scan_ctrl (
    .clk_i(clk), .rst_ni(rst_ni), .ir_i(ir), .ir_update_i(ir_upd),
    .scan_en_i(scan_en), .scan_data_i(scan_data), .mirror_wr_i(mwr),
    .mirror_data_i(mdata), .secret_key_i(SECRET),
    .scan_in_en_o(sin_en), .scan_out_en_o(sout_en), .load_key_o(load_key),
    .scan_shift_o(shift), .scan_out_o(sout), .key_o(key), .mirror_key_o(mkey)
  );

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check_test_mode(string req);
    check(req, {29'd0, sin_en, sout_en, load_key}, 32'b110);
  endtask

  task automatic check_secure_mode(string req);
    check(req, {29'd0, sin_en, sout_en, load_key}, 32'b001);
  endtask

  task automatic t_reset_r1;
    #1;
    check_test_mode("R1 during reset");
    check("R1 mirror in reset", mkey, 0);
    step(2);
    rst_ni = 1'b1;
    step(2);
    check_test_mode("R1 after release");
  endtask

  task automatic t_test_mode_r2_r4;
    scan_en = 1'b1; scan_data = 1'b1; #1;
    check("R2 shift pass", shift, 1);
    check("R2 out pass", sout, 1);
    scan_en = 1'b0; scan_data = 1'b0; #1;
    check("R2 shift low", shift, 0);
    check("R2 out low", sout, 0);
    mdata = 16'h5A3C; mwr = 1'b1;
    step(1);
    mwr = 1'b0;
    check("R4 mirror write", mkey, 16'h5A3C);
    check("R4 key from mirror", key, 16'h5A3C);
  endtask

  task automatic t_wrong_code_r5;
    ir = 4'h3; ir_upd = 1'b1;
    step(1);
    ir_upd = 1'b0;
    step(3);
    check_test_mode("R5 other code ignored");
    // held strobe: code changes to match while strobe stays high
    ir_upd = 1'b1;
    step(1);
    ir = CODE;
    step(4);
    check_test_mode("R5 held strobe no retrigger");
    ir_upd = 1'b0; ir = '0;
    step(1);
    check("R5 mirror kept", mkey, 16'h5A3C);
  endtask

  task automatic t_entry_r5_r6;
    ir = CODE; ir_upd = 1'b1;
    step(1);
    ir_upd = 1'b0;
    check_test_mode("R5 not yet after first edge");
    check("R6 mirror before entry", mkey, 16'h5A3C);
    step(1);
    check_secure_mode("R5 secure after second edge");
    check("R6 mirror cleared with entry", mkey, 0);
  endtask

  task automatic t_secure_r3_r4_r6;
    scan_en = 1'b1; scan_data = 1'b1; #1;
    check("R3 shift blocked", shift, 0);
    check("R3 out forced 0", sout, 0);
    check("R4 key is secret", key, SECRET);
    mdata = 16'hFFFF; mwr = 1'b1;
    step(1);
    mwr = 1'b0;
    check("R6 write ignored in secure", mkey, 0);
    scan_en = 1'b0; scan_data = 1'b0;
  endtask

  task automatic t_sticky_r7;
    logic [15:0] lfsr = 16'hACE1;
    int bad = 0;
    for (int i = 0; i < 200; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      ir = lfsr[3:0]; ir_upd = lfsr[4]; scan_en = lfsr[5];
      scan_data = lfsr[6]; mwr = lfsr[7]; mdata = lfsr;
      step(1);
      if (!(load_key && !sin_en && !sout_en && !sout && mkey == 0)) bad++;
    end
    ir_upd = 1'b0; mwr = 1'b0; scan_en = 1'b0; scan_data = 1'b0;
    check("R7 stays secure under stimulus", bad, 0);
  endtask

  task automatic t_async_reset_r8;
    @(negedge clk);
    #1 rst_ni = 1'b0;
    #0.5;
    check_test_mode("R8 async reset");
    step(1);
    rst_ni = 1'b1;
    step(1);
    check_test_mode("R8 test mode after reset");
  endtask

  initial begin
    t_reset_r1();
    t_test_mode_r2_r4();
    t_wrong_code_r5();
    t_entry_r5_r6();
    t_secure_r3_r4_r6();
    t_sticky_r7();
    t_async_reset_r8();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule